// File: doc/BRIEF.md
# Cascaded FIFO Depth-Expansion Slice

This block is one slice of a FIFO that is built deeper by chaining several identical slices in a ring. Every slice has its own storage and its own read and write pointers. The write strobe, the write data and the read strobe are shared by all slices. Two tokens travel around the ring: the write token and the read token. Only the slice that holds the write token stores a word, and only the slice that holds the read token returns one. A slice passes a token to its successor with a one-cycle pulse on its expansion output. It sends this pulse when the matching pointer reaches the slice's last location. The successor's expansion input is connected to that output, and the last slice feeds back into the first.

When the chain-mode strap is low, the slice works alone as an ordinary FIFO, and its expansion output becomes a half-full indication. Read data is driven as zero whenever the slice returns no word, so the data buses of the whole ring can be merged with an OR. The full and empty outputs work the same way, so they can be merged with an OR as well.

Top module: `cascade_fifo_slice`

## Requirements
- R1: After reset, every slice reports no data (data-valid low, read data zero), the slice strapped as first-load holds both tokens, and in chain mode every expansion output is low. As a result, in a ring only the first-load slice drives its empty output high.
- R2: In single mode (chain-mode strap low) the slice is a FIFO of DEPTH words that returns words in write order. A write strobe while full is ignored, and a read strobe while empty is ignored.
- R3: In single mode the expansion output is high exactly while the stored count is greater than DEPTH/2.
- R4: In chain mode a slice stores the shared write data only while it holds the write token, and it answers a read strobe only while it holds the read token.
- R5: In chain mode, a write accepted into location DEPTH-1 gives up the write token. It also produces a pulse of exactly one clock cycle on the expansion output in the following cycle.
- R6: In chain mode, a read accepted from location DEPTH-1 gives up the read token and produces a one-cycle pulse on the expansion output in the following cycle. If a write pulse and a read pulse fall due in the same cycle, the write pulse is sent first and the read pulse in the next cycle.
- R7: Pulses arriving on the expansion input alternate between the write token and the read token, and the first one after reset is a write token. A slice owns the arriving token already in the cycle the pulse is present.
- R8: A read accepted on one clock edge gives data-valid high and the word on the read-data output after that edge. In every other cycle data-valid is low and read data is zero.
- R9: Three slices connected in a ring behave as one FIFO of 3*DEPTH words. They return words in global write order across any number of token laps.
- R10: The full and empty outputs are driven only by the slice that owns the write or read token respectively. In a ring, the OR of the full outputs is high exactly when 3*DEPTH words are stored, and the OR of the empty outputs is high exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_mode_i | input | 1 | Strap: 1 selects ring operation, 0 selects single mode |
| first_load_i | input | 1 | Strap: 1 marks the slice that owns both tokens after reset |
| xp_in_i | input | 1 | Token pulses from the preceding slice |
| wr_i | input | 1 | Shared write strobe |
| din_i | input | DATA_W | Shared write data |
| rd_i | input | 1 | Shared read strobe |
| dout_o | output | DATA_W | Read data, zero when not valid |
| dvalid_o | output | 1 | Read data valid |
| full_o | output | 1 | Slice owns the write token and is full |
| empty_o | output | 1 | Slice owns the read token and is empty |
| xp_out_o | output | 1 | Token pulses in chain mode, half-full in single mode |

## Verification
The bench goes after the token hand-over cycle, in which the sender has already dropped ownership and the receiver must accept a write or read based only on the incoming pulse. A design that owned the token only from its register would lose one word per lap, and global order would break. The bench also runs the ring through repeated laps near full and near empty. A receiver that confused write pulses with read pulses would then read from the wrong slice, and the merged flags would disagree with the true fill level. Extra strobes at full and at empty, and the half-full boundary in single mode, catch off-by-one count compares and pointers that move when they should be blocked.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    // Token and pulse state of one slice
    typedef struct packed {
        logic own_w;    // write token held
        logic own_r;    // read token held
        logic exp_w;    // next incoming pulse carries the write token
        logic pend_r;   // read pulse deferred behind a write pulse
        logic pulse;    // expansion output register
    } xp_state_t;

    function automatic xp_state_t xp_reset_state(input logic first_load);
        xp_state_t s;
        s.own_w  = first_load;
        s.own_r  = first_load;
        s.exp_w  = 1'b1;
        s.pend_r = 1'b0;
        s.pulse  = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/cfs_store.sv
module cfs_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid,
    output logic              full,
    output logic              empty,
    output logic              half,
    output logic              w_last,
    output logic              r_last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] dout;
        logic              dval;
    } store_t;

    store_t s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[s_q.wp] <= din;
    end

    always_comb begin
        s_d      = s_q;
        s_d.dval = 1'b0;
        s_d.dout = '0;
        if (wr_en) begin
            s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
        end
        if (rd_en) begin
            s_d.dout = mem[s_q.rp];
            s_d.dval = 1'b1;
            s_d.rp   = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout   = s_q.dout;
    assign dvalid = s_q.dval;
    assign full   = (s_q.cnt == FULL_CNT);
    assign empty  = (s_q.cnt == '0);
    assign half   = (s_q.cnt > HALF_CNT);
    assign w_last = wr_en && (s_q.wp == LAST);
    assign r_last = rd_en && (s_q.rp == LAST);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_valid_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> $past(rd_en));
    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> (dout == '0));
endmodule

// File: rtl/cfs_token.sv
module cfs_token
    import cfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chain_mode,
    input  logic first_load,
    input  logic xp_in,
    input  logic w_last,
    input  logic r_last,
    input  logic half,
    output logic own_w,
    output logic own_r,
    output logic xp_out
);
    xp_state_t s_d, s_q;
    logic emit_w, emit_r;

    always_comb begin
        // An arriving pulse grants its token in the same cycle
        own_w = !chain_mode || s_q.own_w || (xp_in && s_q.exp_w);
        own_r = !chain_mode || s_q.own_r || (xp_in && !s_q.exp_w);

        emit_w = chain_mode && w_last;
        emit_r = chain_mode && (r_last || s_q.pend_r);

        s_d        = s_q;
        s_d.own_w  = chain_mode && own_w && !w_last;
        s_d.own_r  = chain_mode && own_r && !r_last;
        s_d.exp_w  = (chain_mode && xp_in) ? !s_q.exp_w : s_q.exp_w;
        s_d.pulse  = emit_w || emit_r;
        s_d.pend_r = emit_w && emit_r;

        xp_out = chain_mode ? s_q.pulse : half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= xp_reset_state(first_load);
        else        s_q <= s_d;
    end

    assert_wpulse_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && w_last) |=> s_q.pulse);
    assert_wtoken_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && w_last) |=> !s_q.own_w);
    assert_rpulse_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && r_last && !w_last) |=> s_q.pulse);
    assert_rtoken_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && r_last) |=> !s_q.own_r);
    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && xp_in) |=> (s_q.exp_w != $past(s_q.exp_w)));
endmodule

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_mode_i,
    input  logic              first_load_i,
    input  logic              xp_in_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dvalid_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              xp_out_o
);
    logic own_w, own_r;
    logic full, empty, half;
    logic wr_en, rd_en;
    logic w_last, r_last;

    assign wr_en = wr_i && own_w && !full;
    assign rd_en = rd_i && own_r && !empty;

    cfs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .din    (din_i),
        .dout   (dout_o),
        .dvalid (dvalid_o),
        .full   (full),
        .empty  (empty),
        .half   (half),
        .w_last (w_last),
        .r_last (r_last)
    );

    cfs_token u_token (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (chain_mode_i),
        .first_load (first_load_i),
        .xp_in      (xp_in_i),
        .w_last     (w_last),
        .r_last     (r_last),
        .half       (half),
        .own_w      (own_w),
        .own_r      (own_r),
        .xp_out     (xp_out_o)
    );

    assign full_o  = own_w && full;
    assign empty_o = own_r && empty;

    assert_no_read_without_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |-> $past(rd_i));
    assert_single_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode_i && $rose(xp_out_o)) |-> $past(wr_i));
endmodule

// File: tb/test_cascade_fifo_slice.sv
module test_cascade_fifo_slice;
    localparam int W = 9;
    localparam int D = 4;
    localparam int N = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n;

    int checks = 0;
    int errors = 0;

    // single-mode device
    logic s_wr, s_rd, s_dv, s_full, s_empty, s_xp;
    logic [W-1:0] s_din, s_dout;

    cascade_fifo_slice #(.DATA_W(W), .DEPTH(D)) i_cascade_fifo_slice (
        .clk(clk), .rst_n(rst_n), .chain_mode_i(1'b0), .first_load_i(1'b1),
        .xp_in_i(1'b0), .wr_i(s_wr), .din_i(s_din), .rd_i(s_rd),
        .dout_o(s_dout), .dvalid_o(s_dv), .full_o(s_full), .empty_o(s_empty),
        .xp_out_o(s_xp)
    );

    // ring of three slices
    logic c_wr, c_rd;
    logic [W-1:0] c_din;
    logic [W-1:0] r_dout [N];
    logic [N-1:0] r_dv, r_full, r_empty, r_xp;

    for (genvar k = 0; k < N; k++) begin : g_ring
        cascade_fifo_slice #(.DATA_W(W), .DEPTH(D)) u_slice (
            .clk(clk), .rst_n(rst_n), .chain_mode_i(1'b1),
            .first_load_i(k == 0), .xp_in_i(r_xp[(k + N - 1) % N]),
            .wr_i(c_wr), .din_i(c_din), .rd_i(c_rd),
            .dout_o(r_dout[k]), .dvalid_o(r_dv[k]), .full_o(r_full[k]),
            .empty_o(r_empty[k]), .xp_out_o(r_xp[k])
        );
    end

    logic [W-1:0] c_dout;
    always_comb begin
        c_dout = '0;
        for (int k = 0; k < N; k++) c_dout = c_dout | r_dout[k];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // models
    logic [W-1:0] sq[$];
    logic [W-1:0] cq[$];
    bit           exp_sv, exp_cv;
    logic [W-1:0] exp_sd, exp_cd;
    logic [N-1:0] exp_xp;
    int           wn, rn;

    function automatic logic [N-1:0] pulse_for(input int idx);
        logic [N-1:0] v = '0;
        if (idx % D == D - 1) v[(idx / D) % N] = 1'b1;
        return v;
    endfunction

    task automatic single_step(input bit wr, input bit rd, input logic [W-1:0] d);
        bit aw, ar;
        @(negedge clk);
        chk(s_dv == exp_sv, "R8 single valid", s_dv, exp_sv);
        if (exp_sv) chk(s_dout == exp_sd, "R2 single order", s_dout, exp_sd);
        else        chk(s_dout == '0, "R8 single idle bus", s_dout, 0);
        chk(s_full == (sq.size() == D), "R2 single full", s_full, sq.size() == D);
        chk(s_empty == (sq.size() == 0), "R2 single empty", s_empty, sq.size() == 0);
        chk(s_xp == (sq.size() > D / 2), "R3 half flag", s_xp, sq.size() > D / 2);
        ar = rd && (sq.size() > 0);
        aw = wr && (sq.size() < D);
        exp_sv = ar;
        if (ar) exp_sd = sq.pop_front();
        if (aw) sq.push_back(d);
        s_wr = wr; s_rd = rd; s_din = d;
    endtask

    task automatic ring_step(input bit wr, input bit rd, input logic [W-1:0] d);
        bit aw, ar;
        @(negedge clk);
        chk(r_dv != '0 == exp_cv, "R8 ring valid", r_dv, exp_cv);
        chk($countones(r_dv) <= 1, "R4 single reader", r_dv, 0);
        if (exp_cv) chk(c_dout == exp_cd, "R9 global order", c_dout, exp_cd);
        else        chk(c_dout == '0, "R8 ring idle bus", c_dout, 0);
        chk(r_xp == exp_xp, "R5/R6 token pulses", r_xp, exp_xp);
        chk((|r_full) == (cq.size() == N * D), "R10 merged full", r_full, cq.size() == N * D);
        chk((|r_empty) == (cq.size() == 0), "R10 merged empty", r_empty, cq.size() == 0);
        ar = rd && (cq.size() > 0);
        aw = wr && (cq.size() < N * D);
        exp_xp = '0;
        exp_cv = ar;
        if (ar) begin
            exp_cd = cq.pop_front();
            exp_xp = exp_xp | pulse_for(rn);
            rn++;
        end
        if (aw) begin
            cq.push_back(d);
            exp_xp = exp_xp | pulse_for(wn);
            wn++;
        end
        c_wr = wr; c_rd = rd; c_din = d;
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        s_wr = 0; s_rd = 0; s_din = '0;
        c_wr = 0; c_rd = 0; c_din = '0;
        exp_sv = 0; exp_cv = 0; exp_sd = '0; exp_cd = '0; exp_xp = '0;
        wn = 0; rn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(r_empty == 3'b001, "R1 first-load owns read token", r_empty, 3'b001);
        chk(r_full == '0, "R1 ring not full", r_full, 0);
        chk(r_xp == '0, "R1 no pulses", r_xp, 0);
        chk(r_dv == '0, "R1 ring valid low", r_dv, 0);
        chk(s_empty && !s_full, "R1 single empty", {s_full, s_empty}, 1);
        chk(s_xp == 1'b0 && s_dv == 1'b0, "R1 single quiet", {s_xp, s_dv}, 0);

        // R2/R3 directed: overfill then overdrain
        for (int i = 0; i < D + 2; i++) single_step(1'b1, 1'b0, W'(9'h100 + i));
        for (int i = 0; i < D + 2; i++) single_step(1'b0, 1'b1, '0);
        single_step(1'b0, 1'b0, '0);
        for (int i = 0; i < 400; i++)
            single_step(($urandom % 100) < 55, ($urandom % 100) < 45, W'($urandom));
        while (sq.size() > 0) single_step(1'b0, 1'b1, '0);
        single_step(1'b0, 1'b0, '0);

        // R4/R7/R9 directed: fill the ring past capacity, then drain past empty
        for (int i = 0; i < N * D + 2; i++) ring_step(1'b1, 1'b0, W'(9'h0A0 + i));
        for (int i = 0; i < N * D + 2; i++) ring_step(1'b0, 1'b1, '0);
        // streaming with simultaneous strobes over several laps
        for (int i = 0; i < 40; i++) ring_step(1'b1, i > 2, W'(i * 7));
        for (int i = 0; i < 3000; i++)
            ring_step(($urandom % 100) < 52, ($urandom % 100) < 48, W'($urandom));
        while (cq.size() > 0) ring_step(1'b0, 1'b1, '0);
        ring_step(1'b0, 1'b0, '0);
        ring_step(1'b0, 1'b0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule